// File: doc/BRIEF.md
# Serial-Loaded Output Freeze Controller

This block decides which clock outputs of a multi-bank clock buffer run and which are held stopped. A free-running serial clock and a serial data line load a frame: the receiver waits in idle for a low start bit, then takes the next twelve data bits, one per serial clock period. Once the last bit has arrived, all twelve enable bits take effect together and the receiver returns to idle to wait for the next start bit.

Each enable bit drives one output gate. A gate passes its source clock when its bit is 1 and holds the output low when its bit is 0. The gate state is held in a flop clocked on the falling edge of that output's own source clock. An output therefore starts or stops only between pulses, and every pulse it passes has full width. Lane 0 of bank C and the feedback output have no enable bit and cannot be frozen. An active-low master reset/output-enable input forces every output low, clears the receiver, and sets every enable bit back to 1.

Top module: `out_freeze_ctrl`

## Requirements
- R1: While idle, a 0 on `sdata` at a rising edge of `sclk` is a start bit. The next 12 rising edges capture data bits D0 to D11 in that order.
- R2: While idle, a 1 on `sdata` is ignored. The enables stay unchanged and the receiver stays idle.
- R3: Bit mapping: D0..D3 drive `qa[0..3]`, D4..D7 drive `qb[0..3]`, D8..D10 drive `qc[1..3]`, and D11 drives `sync_o`.
- R4: An enable bit of 0 holds its output at logic 0. An enable bit of 1 makes the output follow its source clock.
- R5: `qc[0]` and `fb_o` always follow `src_c` and `src_fb` while `mrst_oe_n` is high, whatever frame was loaded.
- R6: A gate opens or closes only while its source clock is low. Every output pulse spans a whole high phase of its source clock.
- R7: While `mrst_oe_n` is low, all outputs, including `qc[0]` and `fb_o`, are low. Any previously loaded freeze pattern is cleared.
- R8: A frame changes nothing until its 12th data bit is captured. All 12 bits then take effect together.
- R9: After reset every enable bit is 1, so every output runs until a frame is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Free-running serial clock; data sampled on its rising edge |
| sdata | input | 1 | Serial frame data (start bit 0, then D0..D11) |
| mrst_oe_n | input | 1 | Active-low master reset and output enable |
| src_a | input | 1 | Source clock for bank A |
| src_b | input | 1 | Source clock for bank B |
| src_c | input | 1 | Source clock for bank C |
| src_sync | input | 1 | Source waveform for the sync output |
| src_fb | input | 1 | Source clock for the feedback output |
| qa | output | LANES | Bank A gated outputs |
| qb | output | LANES | Bank B gated outputs |
| qc | output | LANES | Bank C gated outputs (lane 0 never frozen) |
| sync_o | output | 1 | Gated sync output |
| fb_o | output | 1 | Feedback output (never frozen) |

## Verification
The assertions assume that `mrst_oe_n` is held low for at least one falling edge of every source clock, so that each gate flop has been cleared. They also assume that `sdata` changes away from rising edges of `sclk`. The stimulus keeps a long reset with all sources running and drives `sdata` only on falling serial edges. It changes `mrst_oe_n` only while the pulse-width monitor is switched off, because a deliberate disable may cut a pulse short.

// File: rtl/freeze_pkg.sv
package freeze_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/frame_rx.sv
module frame_rx
  import freeze_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             sclk,
  input  logic             rst,
  input  logic             sdata,
  output logic [NBITS-1:0] en_o
);
  localparam int CW = $clog2(NBITS);

  rx_state_e        st;
  logic [CW-1:0]    cnt;
  logic [NBITS-2:0] sh;
  logic             last;

  assign last = (st == RX_DATA) && (cnt == CW'(NBITS - 1));

  always_ff @(posedge sclk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      sh   <= '0;
      en_o <= '1;
    end else begin
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!sdata) st <= RX_DATA;
        end
        RX_DATA: begin
          sh <= {sdata, sh[NBITS-2:1]};
          if (last) begin
            en_o <= {sdata, sh};
            st   <= RX_IDLE;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R1: a low bit seen in idle opens a frame at bit index zero
  p_start_r1: assert property (@(posedge sclk) disable iff (rst)
    (st == RX_IDLE && !sdata) |=> (st == RX_DATA && cnt == '0));

  // R2: a high line in idle keeps the receiver idle and enables unchanged
  p_idle_hold_r2: assert property (@(posedge sclk) disable iff (rst)
    (st == RX_IDLE && sdata) |=> (st == RX_IDLE && $stable(en_o)));

  // R8: enables move only in the cycle after the final data bit
  p_commit_only_r8: assert property (@(posedge sclk) disable iff (rst)
    !$past(last) |-> $stable(en_o));

  // R9: reset leaves every output enabled
  p_reset_ones_r9: assert property (@(posedge sclk) disable iff (rst)
    $past(rst) |-> (en_o == '1));
endmodule

// File: rtl/clk_gate.sv
module clk_gate (
  input  logic src_clk,
  input  logic oe,
  input  logic en_in,
  output logic clk_o
);
  logic rst;
  logic gate_q;

  assign rst = ~oe;

  always_ff @(negedge src_clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= en_in;
  end

  assign clk_o = src_clk & gate_q & oe;

  // R6: the gate state may change only while the source clock is low
  always @(gate_q) begin
    if (oe) p_gate_moves_low_r6: assert (src_clk == 1'b0);
  end

  // R4: a cleared enable closes the gate at the next falling edge
  p_freeze_closes_r4: assert property (@(negedge src_clk) disable iff (rst)
    !en_in |=> !gate_q);
endmodule

// File: rtl/out_freeze_ctrl.sv
module out_freeze_ctrl #(
  parameter int LANES = 4
) (
  input  logic             sclk,
  input  logic             sdata,
  input  logic             mrst_oe_n,
  input  logic             src_a,
  input  logic             src_b,
  input  logic             src_c,
  input  logic             src_sync,
  input  logic             src_fb,
  output logic [LANES-1:0] qa,
  output logic [LANES-1:0] qb,
  output logic [LANES-1:0] qc,
  output logic             sync_o,
  output logic             fb_o
);
  localparam int NBITS = 3 * LANES;
  localparam int B_OFS = LANES;
  localparam int C_OFS = 2 * LANES - 1;

  logic             rst;
  logic [NBITS-1:0] en;

  assign rst = ~mrst_oe_n;

  frame_rx #(.NBITS(NBITS)) u_rx (
    .sclk  (sclk),
    .rst   (rst),
    .sdata (sdata),
    .en_o  (en)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    clk_gate u_ga (.src_clk(src_a), .oe(mrst_oe_n), .en_in(en[l]),         .clk_o(qa[l]));
    clk_gate u_gb (.src_clk(src_b), .oe(mrst_oe_n), .en_in(en[B_OFS + l]), .clk_o(qb[l]));
    if (l == 0) begin : g_c_fixed
      clk_gate u_gc (.src_clk(src_c), .oe(mrst_oe_n), .en_in(1'b1), .clk_o(qc[l]));
    end else begin : g_c_ctl
      clk_gate u_gc (.src_clk(src_c), .oe(mrst_oe_n), .en_in(en[C_OFS + l]), .clk_o(qc[l]));
    end
  end

  clk_gate u_gsync (.src_clk(src_sync), .oe(mrst_oe_n), .en_in(en[NBITS-1]), .clk_o(sync_o));
  clk_gate u_gfb   (.src_clk(src_fb),   .oe(mrst_oe_n), .en_in(1'b1),        .clk_o(fb_o));

  // R7: disable forces every output low
  p_disable_r7: assert property (@(posedge sclk)
    !mrst_oe_n |-> (qa == '0 && qb == '0 && qc == '0 && !sync_o && !fb_o));

  // R5: exempt outputs track their sources whenever enabled
  p_exempt_r5: assert property (@(posedge sclk) disable iff (rst)
    (qc[0] == src_c) && (fb_o == src_fb));
endmodule

// File: tb/test_out_freeze_ctrl.sv
`timescale 1ns/1ps
module test_out_freeze_ctrl;
  logic sclk = 1'b0, run = 1'b1;
  logic sdata = 1'b1, mrst_oe_n = 1'b0;
  logic src_a = 0, src_b = 0, src_c = 0, src_sync = 0, src_fb = 0;
  logic [3:0] qa, qb, qc;
  logic sync_o, fb_o;
  int errors = 0, checks = 0, runt_err = 0;
  logic mon_en = 1'b0;
  bit done = 0;

  out_freeze_ctrl #(.LANES(4)) i_out_freeze_ctrl (
    .sclk(sclk), .sdata(sdata), .mrst_oe_n(mrst_oe_n),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .src_sync(src_sync), .src_fb(src_fb),
    .qa(qa), .qb(qb), .qc(qc), .sync_o(sync_o), .fb_o(fb_o)
  );

  initial forever begin #2.5; if (run) sclk = ~sclk; end
  always #7  src_a = ~src_a;
  always #11 src_b = ~src_b;
  always #13 src_c = ~src_c;
  always #17 src_sync = ~src_sync;
  always #9  src_fb = ~src_fb;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R6 monitor: qa[0] never high while src_a low; each full pulse lasts 14 half-ns samples
  initial begin
    int hi = 0; bit prev = 0, vld = 0;
    #0.25;
    forever begin
      if (!mon_en) begin hi = 0; vld = 0; end
      else begin
        if (qa[0] && !src_a) runt_err++;
        if (qa[0]) hi++;
        else begin
          if (prev && vld && hi != 14) runt_err++;
          hi = 0; vld = 1;
        end
      end
      prev = qa[0];
      #0.5;
    end
  end

  // expected output = source & enable & oe, over a window; also proves frozen outputs stay low
  task automatic observe(input logic [11:0] d, input string req);
    logic [13:0] expv, bad, ov, sv;
    real t;
    expv = {1'b1, d[11], d[10:8], 1'b1, d[7:0]};
    t = $realtime;
    #(($floor(t) + 1.25) - t);
    #40;
    bad = '0;
    for (int k = 0; k < 120; k++) begin
      #1;
      ov = {fb_o, sync_o, qc, qb, qa};
      sv = {src_fb, src_sync, {4{src_c}}, {4{src_b}}, {4{src_a}}};
      bad |= ov ^ (sv & expv & {14{mrst_oe_n}});
    end
    for (int b = 0; b < 14; b++)
      chk(!bad[b], req, $sformatf("output bit %0d mismatch", b), 32'(bad[b]), 32'h0);
  endtask

  task automatic send_frame(input logic [11:0] d);
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < 12; i++) @(negedge sclk) sdata = d[i];
    @(negedge sclk) sdata = 1'b1;
  endtask

  task automatic do_reset;
    mon_en = 1'b0;
    @(negedge sclk) mrst_oe_n = 1'b0;
    repeat (20) @(negedge sclk);
    observe(12'hFFF & 12'h000, "R7 disabled");
    @(negedge sclk) mrst_oe_n = 1'b1;
    #40 mon_en = 1'b1;
  endtask

  task automatic t_reset_default;  // R9
    observe(12'hFFF, "R9");
  endtask

  task automatic t_mapping;  // R1 R3 R4
    send_frame(12'h001); observe(12'h001, "R3 qa0 only");
    send_frame(12'h800); observe(12'h800, "R3 sync only");
    send_frame(12'h5A6); observe(12'h5A6, "R1 R4 mixed");
    send_frame(12'h0F0); observe(12'h0F0, "R3 bank B only");
  endtask

  task automatic t_exempt;  // R5
    send_frame(12'h000); observe(12'h000, "R5 all frozen");
  endtask

  task automatic t_idle_ignore;  // R2
    send_frame(12'h3C9);
    @(negedge sclk) sdata = 1'b1;
    repeat (30) @(negedge sclk);
    observe(12'h3C9, "R2 idle high");
    send_frame(12'hC36); observe(12'hC36, "R2 next frame aligned");
  endtask

  task automatic t_commit_together;  // R8
    logic [11:0] d = 12'h924;
    send_frame(12'hFFF);
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < 11; i++) @(negedge sclk) sdata = d[i];
    @(posedge sclk);
    @(negedge sclk) run = 1'b0;
    observe(12'hFFF, "R8 before last bit");
    run = 1'b1; sdata = d[11];
    @(negedge sclk) sdata = 1'b1;
    observe(d, "R8 after last bit");
  endtask

  task automatic t_glitch;  // R6
    for (int k = 0; k < 6; k++) begin
      send_frame(k[0] ? 12'hFFF : 12'hFFE);
      repeat (k + 3) @(negedge sclk);
    end
    observe(12'hFFF, "R6 after toggling");
    chk(runt_err == 0, "R6", "partial pulses on qa0", 32'(runt_err), 32'h0);
  endtask

  task automatic t_disable_clears;  // R7
    send_frame(12'h000);
    do_reset();
    observe(12'hFFF, "R7 pattern cleared");
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_default();
    t_mapping();
    t_exempt();
    t_idle_ignore();
    t_commit_together();
    t_glitch();
    t_disable_clears();
    chk(runt_err == 0, "R6", "partial pulses overall", 32'(runt_err), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule